// File: doc/BRIEF.md
# Key-protected dual-stage watchdog timer

This block is a watchdog peripheral for a large chip. Software programs it over a simple 32-bit register bus with an address, write data, a write strobe and combinational read data. It counts on a slow tick enable of about 32 kHz. If software stops kicking it, it raises an interrupt, drives a system reset, or does both in turn. No write reaches any register unless it carries a fixed key pattern or one exact magic value. A stray store from software that has gone astray therefore can neither disarm the timer nor set off a reset.

The timeout is set in units of `TICKS_PER_UNIT` ticks (512 by default, about 1/64 s at 32 kHz). When an expiry occurs, the mode register selects what happens. In single-interrupt mode the block raises an interrupt and does nothing more. With the interrupt disabled it resets at once. In dual mode it warns first and resets only if a second full period passes without a kick. A reset pulse lasts a fixed number of ticks and also appears on an external pin whose active level is programmable.

Top module: `keyed_wdog`

## Requirements
- R1: A write to address 0x00 (mode) changes the register only when data bits [31:24] are 0x22. The stored fields are: enable at bit 0, external polarity at bit 1 (1 means active high), external pin enable at bit 2, interrupt enable at bit 3, auto-start at bit 4, dual mode at bit 6 and counter select at bit 8. A read returns exactly these bits, with every other bit reading 0.
- R2: A write to address 0x04 (length) changes the register only when data bits [4:0] are 0x08. The count is taken from bits [5 +: LEN_BITS]. A read returns the count shifted left by 5, with the key bits reading 0. Any address other than 0x00 or 0x04 reads 0.
- R3: After a reload, expiry happens on the L*TICKS_PER_UNIT-th tick, where L is the programmed count. A count of 0 expires on the first tick.
- R4: Writing exactly 0x1971 to address 0x08 reloads the counter and clears the interrupt and the warning stage. Writing any other value there has no effect.
- R5: With the interrupt enabled and dual mode off, an expiry raises the interrupt and no reset. The interrupt stays high through later expiries.
- R6: With the interrupt disabled, an expiry asserts the system reset.
- R7: With dual mode and the interrupt both enabled, the first expiry raises the interrupt and reloads the counter. A second expiry with no kick in between drops the interrupt and asserts the reset.
- R8: Writing exactly 0x1209 to address 0x14 asserts the system reset on the next cycle. Any other value written there is ignored.
- R9: A reset lasts RST_HOLD ticks (16 by default) and is then released. Mode and length survive it. Counting pauses while the reset is held, then resumes from the full length.
- R10: Clearing the enable bit stops counting and clears the interrupt and the warning stage. Setting the enable bit from 0 to 1 reloads the counter.
- R11: When the external pin is enabled, it sits at the polarity level while the reset is active and at the opposite level otherwise. When the pin is disabled, it always sits at the opposite level.
- R12: The interrupt and the system reset are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Power-on reset, active low |
| tickEn | input | 1 | Slow tick enable, one cycle per tick |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe |
| busRdata | output | 32 | Read data for busAddr |
| irqOut | output | 1 | Early-warning interrupt |
| sysRstOut | output | 1 | System reset, active high |
| extRstOut | output | 1 | External reset pin, programmable level |

## Verification
The hardest state to reach is the second expiry in dual mode. The counter must run two full periods with no kick between them, and the stage bit behind that escalation cannot be seen except through the timing of the reset. The bench therefore controls the tick enable cycle by cycle and sweeps small lengths with a shortened tick unit. It samples one tick before and one tick after each predicted edge. It also places a kick between the two stages to show that escalation starts over. The release of the held reset, and the full-length reload after it, are reached the same way.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Register byte offsets; software depends on them.
  localparam logic [7:0] ADDR_MODE  = 8'h00;
  localparam logic [7:0] ADDR_LEN   = 8'h04;
  localparam logic [7:0] ADDR_KICK  = 8'h08;
  localparam logic [7:0] ADDR_SWRST = 8'h14;

  localparam logic [7:0]  MODE_KEY  = 8'h22;
  localparam logic [4:0]  LEN_KEY   = 5'h08;
  localparam logic [31:0] KICK_VAL  = 32'h0000_1971;
  localparam logic [31:0] SWRST_VAL = 32'h0000_1209;

  typedef struct packed {
    logic cntSel;
    logic dual;
    logic autoStart;
    logic irqEn;
    logic extEn;
    logic pol;
    logic en;
  } modeBits_t;

  // Strobes from control to the counting datapath.
  typedef struct packed {
    logic load;
    logic run;
    logic holdStart;
  } cntStrobe_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int LEN_BITS = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          busAddr,
  input  logic [31:0]         busWdata,
  input  logic                busWe,
  output logic [31:0]         busRdata,
  output modeBits_t           modeQ,
  output logic [LEN_BITS-1:0] lenQ,
  output logic                kickHit,
  output logic                swRstHit,
  output logic                enRise
);
  localparam int PAD_W = 27 - LEN_BITS;

  logic modeWr, lenWr;

  always_comb begin
    modeWr   = busWe && (busAddr == ADDR_MODE) && (busWdata[31:24] == MODE_KEY);
    lenWr    = busWe && (busAddr == ADDR_LEN) && (busWdata[4:0] == LEN_KEY);
    kickHit  = busWe && (busAddr == ADDR_KICK) && (busWdata == KICK_VAL);
    swRstHit = busWe && (busAddr == ADDR_SWRST) && (busWdata == SWRST_VAL);
    enRise   = modeWr && busWdata[0] && !modeQ.en;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      lenQ  <= '0;
    end else begin
      if (modeWr) begin
        modeQ <= '{cntSel: busWdata[8], dual: busWdata[6], autoStart: busWdata[4],
                   irqEn: busWdata[3], extEn: busWdata[2], pol: busWdata[1],
                   en: busWdata[0]};
      end
      if (lenWr) lenQ <= busWdata[5 +: LEN_BITS];
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_MODE: busRdata = {23'b0, modeQ.cntSel, 1'b0, modeQ.dual, 1'b0,
                             modeQ.autoStart, modeQ.irqEn, modeQ.extEn,
                             modeQ.pol, modeQ.en};
      ADDR_LEN:  busRdata = {{PAD_W{1'b0}}, lenQ, 5'b0};
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeEn,
  input  logic       irqEn,
  input  logic       dualEn,
  input  logic       kickHit,
  input  logic       swRstHit,
  input  logic       enRise,
  input  logic       expHit,
  input  logic       holdBusy,
  output cntStrobe_t strb,
  output logic       irqOut
);
  logic irqQ, stageQ;
  logic expEff, escalate, fire, warn;

  always_comb begin
    // A kick or a fresh enable in the same cycle wins over an expiry.
    expEff   = expHit && !kickHit && !enRise;
    escalate = !irqEn || (dualEn && stageQ);
    fire     = swRstHit || (expEff && escalate);
    warn     = expEff && !escalate;
    strb.run       = modeEn && !holdBusy;
    strb.load      = kickHit || enRise || expEff || swRstHit;
    strb.holdStart = fire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ   <= 1'b0;
      stageQ <= 1'b0;
    end else if (!modeEn || kickHit || fire) begin
      irqQ   <= 1'b0;
      stageQ <= 1'b0;
    end else if (warn) begin
      irqQ   <= 1'b1;
      stageQ <= dualEn;
    end
  end

  assign irqOut = irqQ;
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int LEN_BITS       = 11,
  parameter int TICKS_PER_UNIT = 512,
  parameter int RST_HOLD       = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  cntStrobe_t          strb,
  input  logic [LEN_BITS-1:0] lenQ,
  output logic                expHit,
  output logic                holdBusy
);
  localparam int CNT_W  = LEN_BITS + $clog2(TICKS_PER_UNIT) + 1;
  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  logic [CNT_W-1:0]  cntQ, loadVal;
  logic [HOLD_W-1:0] holdQ;

  always_comb begin
    loadVal  = CNT_W'(lenQ) * CNT_W'(TICKS_PER_UNIT);
    expHit   = strb.run && tickEn && (cntQ <= CNT_W'(1));
    holdBusy = (holdQ != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.load) begin
      cntQ <= loadVal;
    end else if (strb.run && tickEn && (cntQ != '0)) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (strb.holdStart) begin
      holdQ <= HOLD_W'(RST_HOLD);
    end else if (tickEn && holdBusy) begin
      holdQ <= holdQ - HOLD_W'(1);
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int LEN_BITS       = 11,
  parameter int TICKS_PER_UNIT = 512,
  parameter int RST_HOLD       = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  input  logic        busWe,
  output logic [31:0] busRdata,
  output logic        irqOut,
  output logic        sysRstOut,
  output logic        extRstOut
);
  modeBits_t           modeQ;
  logic [LEN_BITS-1:0] lenQ;
  logic                kickHit, swRstHit, enRise, expHit, holdBusy;
  cntStrobe_t          strb;

  wdog_regs #(.LEN_BITS(LEN_BITS)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .modeQ(modeQ), .lenQ(lenQ),
    .kickHit(kickHit), .swRstHit(swRstHit), .enRise(enRise)
  );

  wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeEn(modeQ.en), .irqEn(modeQ.irqEn),
    .dualEn(modeQ.dual), .kickHit(kickHit), .swRstHit(swRstHit),
    .enRise(enRise), .expHit(expHit), .holdBusy(holdBusy), .strb(strb),
    .irqOut(irqOut)
  );

  wdog_count #(
    .LEN_BITS(LEN_BITS), .TICKS_PER_UNIT(TICKS_PER_UNIT), .RST_HOLD(RST_HOLD)
  ) u_count (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb), .lenQ(lenQ),
    .expHit(expHit), .holdBusy(holdBusy)
  );

  assign sysRstOut = holdBusy;
  assign extRstOut = (modeQ.extEn && holdBusy) ? modeQ.pol : !modeQ.pol;
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
  import wdog_pkg::*;
#(
  parameter int LEN_BITS = 11
) (
  input logic                clk,
  input logic                rstN,
  input logic                tickEn,
  input logic [7:0]          busAddr,
  input logic [31:0]         busWdata,
  input logic                busWe,
  input logic                irqOut,
  input logic                sysRstOut,
  input logic                extRstOut,
  input modeBits_t           modeQ,
  input logic [LEN_BITS-1:0] lenQ
);
  assert_mode_key_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_MODE && busWdata[31:24] != MODE_KEY) |=> $stable(modeQ));

  assert_len_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_LEN && busWdata[4:0] != LEN_KEY) |=> $stable(lenQ));

  assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_KICK && busWdata == KICK_VAL) |=> !irqOut);

  assert_swrst_next_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_SWRST && busWdata == SWRST_VAL) |=> sysRstOut);

  assert_release_on_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysRstOut) |-> $past(tickEn));

  assert_disable_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ.en |=> !irqOut);

  assert_ext_level_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sysRstOut) && modeQ.extEn && $stable(modeQ)) |-> (extRstOut == modeQ.pol));

  assert_irq_rst_apart_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(irqOut && sysRstOut));
endmodule

bind keyed_wdog keyed_wdog_chk #(.LEN_BITS(LEN_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
  .busWdata(busWdata), .busWe(busWe), .irqOut(irqOut),
  .sysRstOut(sysRstOut), .extRstOut(extRstOut), .modeQ(modeQ), .lenQ(lenQ)
);

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TPU  = 4;
  localparam int HOLD = 16;
  localparam logic [31:0] MK  = 32'h2200_0000;
  localparam logic [31:0] EN  = 32'h1, POL = 32'h2, EXT = 32'h4, IRQ = 32'h8, DUAL = 32'h40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut, sysRstOut, extRstOut;
  int nVec = 0, nBad = 0;
  bit done = 1'b0;

  keyed_wdog #(.LEN_BITS(11), .TICKS_PER_UNIT(TPU), .RST_HOLD(HOLD)) u_keyed_wdog (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRdata(busRdata),
    .irqOut(irqOut), .sysRstOut(sysRstOut), .extRstOut(extRstOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
    end
    tickEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input int len, input logic [31:0] mode);
    wr(8'h00, MK);
    idle(1);
    wr(8'h04, (32'(len) << 5) | 32'h8);
    wr(8'h00, MK | mode);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // Reset state
    check("R11 reset irq", 32'(irqOut), 0);
    check("R11 reset sysRst", 32'(sysRstOut), 0);
    check("R11 reset ext idle", 32'(extRstOut), 1);
    rd(8'h00, r); check("R1 reset mode", r, 0);
    rd(8'h04, r); check("R2 reset len", r, 0);

    // R1: key on mode
    wr(8'h00, 32'h1100_015F);
    rd(8'h00, r); check("R1 bad key ignored", r, 0);
    wr(8'h00, 32'h22FF_FFFE);
    rd(8'h00, r); check("R1 fields only", r, 32'h15E);
    wr(8'h00, MK);
    rd(8'h00, r); check("R1 cleared", r, 0);

    // R2: key on length, field and readback sweep
    for (int v = 0; v < 40; v += 7) begin
      wr(8'h04, (32'(v) << 5) | 32'h9);
      rd(8'h04, r); check("R2 bad key ignored", r, (v == 0) ? 0 : 32'(v - 7) << 5);
      wr(8'h04, 32'hFFF0_0000 | (32'(v) << 5) | 32'h8);
      rd(8'h04, r); check("R2 len readback", r, 32'(v) << 5);
    end
    rd(8'h08, r); check("R2 kick reads 0", r, 0);
    rd(8'h20, r); check("R2 other reads 0", r, 0);

    // R3/R5/R4: single interrupt mode sweep
    for (int len = 1; len <= 5; len++) begin
      setup(len, EN | IRQ);
      ticks(len * TPU - 1); check("R3 before expiry", 32'(irqOut), 0);
      ticks(1); check("R3 irq at expiry", 32'(irqOut), 1);
      check("R5 no reset", 32'(sysRstOut), 0);
      ticks(len * TPU); check("R5 irq held", 32'(irqOut), 1);
      check("R5 still no reset", 32'(sysRstOut), 0);
      wr(8'h08, 32'h1970); check("R4 bad kick ignored", 32'(irqOut), 1);
      wr(8'h08, 32'h1971); check("R4 kick clears irq", 32'(irqOut), 0);
      ticks(len * TPU - 1); check("R4 reload full", 32'(irqOut), 0);
      ticks(1); check("R4 expiry after kick", 32'(irqOut), 1);
    end

    // R3: zero length expires on first tick
    setup(0, EN | IRQ);
    check("R3 len0 idle", 32'(irqOut), 0);
    ticks(1); check("R3 len0 first tick", 32'(irqOut), 1);

    // R4: kick mid-count
    setup(3, EN | IRQ);
    ticks(10);
    wr(8'h08, 32'h1971);
    ticks(11); check("R4 mid kick reload", 32'(irqOut), 0);
    ticks(1); check("R4 mid kick expiry", 32'(irqOut), 1);

    // R6/R9/R11: reset mode sweep, active-high pin
    for (int len = 1; len <= 4; len++) begin
      setup(len, EN | EXT | POL);
      ticks(len * TPU - 1); check("R6 before expiry", 32'(sysRstOut), 0);
      check("R11 high idle", 32'(extRstOut), 0);
      ticks(1); check("R6 reset at expiry", 32'(sysRstOut), 1);
      check("R11 high active", 32'(extRstOut), 1);
      check("R6 no irq", 32'(irqOut), 0);
      ticks(HOLD - 1); check("R9 still held", 32'(sysRstOut), 1);
      ticks(1); check("R9 released", 32'(sysRstOut), 0);
      check("R11 high released", 32'(extRstOut), 0);
      rd(8'h00, r); check("R9 mode kept", r, EN | EXT | POL);
      rd(8'h04, r); check("R9 len kept", r, 32'(len) << 5);
      ticks(len * TPU - 1); check("R9 full reload", 32'(sysRstOut), 0);
      ticks(1); check("R9 second reset", 32'(sysRstOut), 1);
      ticks(HOLD);
    end

    // R7: dual mode sweep, active-low pin
    for (int len = 1; len <= 3; len++) begin
      setup(len, EN | IRQ | DUAL | EXT);
      ticks(len * TPU); check("R7 stage one irq", 32'(irqOut), 1);
      check("R7 stage one no reset", 32'(sysRstOut), 0);
      ticks(len * TPU - 1); check("R7 waiting", 32'(sysRstOut), 0);
      ticks(1); check("R7 escalated reset", 32'(sysRstOut), 1);
      check("R7 irq dropped", 32'(irqOut), 0);
      check("R11 low active", 32'(extRstOut), 0);
      ticks(HOLD); check("R11 low released", 32'(extRstOut), 1);
      // A kick between the stages starts over
      setup(len, EN | IRQ | DUAL);
      ticks(len * TPU);
      wr(8'h08, 32'h1971);
      ticks(len * TPU); check("R7 restart stage one", 32'(irqOut), 1);
      check("R7 no reset after kick", 32'(sysRstOut), 0);
    end

    // R8: software reset
    wr(8'h00, MK);
    wr(8'h14, 32'h1208); check("R8 wrong value", 32'(sysRstOut), 0);
    wr(8'h14, 32'h1209); check("R8 immediate", 32'(sysRstOut), 1);
    ticks(HOLD - 1); check("R8 held", 32'(sysRstOut), 1);
    ticks(1); check("R8 released", 32'(sysRstOut), 0);

    // R10: disable stops and clears, enable reloads
    setup(3, EN | IRQ);
    ticks(12); check("R10 irq up", 32'(irqOut), 1);
    wr(8'h00, MK | IRQ);
    idle(1); check("R10 disable clears", 32'(irqOut), 0);
    ticks(50); check("R10 stopped", 32'(irqOut), 0);
    wr(8'h00, MK | IRQ | EN);
    ticks(11); check("R10 enable reload", 32'(irqOut), 0);
    ticks(1); check("R10 expiry after enable", 32'(irqOut), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule